// File: doc/BRIEF.md
# Operand Address Generator for mod/r/m Encoded Instructions

This block turns the addressing fields of an already decoded instruction into either a 16-bit memory offset or a register-operand selector. It takes the 2-bit mode field, the 3-bit register/memory field and the width bit. It also takes the current contents of the four base and index registers and the two displacement bytes that follow the addressing byte. The caller presents all of these together with a one-cycle valid strobe. The result appears on registered outputs in the next cycle.

The mode field picks one of three memory forms or the register form. The memory forms are: no displacement, a signed byte displacement, or a word displacement. Each memory form adds one of eight base combinations to the displacement. The one irregular entry is mode 0 with field 110, which names an absolute address held in the displacement bytes. A combinational count of the displacement bytes the fields imply is also provided, so that the instruction fetch logic upstream knows how many bytes to take. The address sum wraps modulo 65536 and has no overflow flag.

Top module: `modrm_addr_unit`

## Requirements
- R1: While `rstN` is low and after its release until the first strobe, `outValid`, `isRegister`, `regWide`, `regSel` and `effAddr` are all zero.
- R2: A high `inValid` at a rising edge gives `outValid` high after that edge, with results computed from the inputs sampled at that edge. A low `inValid` gives `outValid` low, and `effAddr`, `isRegister`, `regSel` and `regWide` keep their previous values.
- R3: Mode 11 is the register form. `isRegister` is 1, `effAddr` is 0 and `regSel` equals the r/m field. Codes 0–7 are AL,CL,DL,BL,AH,CH,DH,BH when `regWide`=0 and AX,CX,DX,BX,SP,BP,SI,DI when `regWide`=1.
- R4: `regWide` always follows the sampled `wBit`. In the memory forms, `isRegister` is 0 and `regSel` is 0.
- R5: In modes 00, 01 and 10, r/m codes 0 through 7 use the bases BX+SI, BX+DI, BP+SI, BP+DI, SI, DI, BP and BX.
- R6: Mode 00 adds no displacement. The exception is r/m 110, where the address is {dispHi,dispLo} and no register is added.
- R7: Mode 01 adds `dispLo` sign-extended to 16 bits, by copying bit 7 into the upper byte. `dispHi` is ignored.
- R8: Mode 10 adds the 16-bit word {dispHi,dispLo}, whose low byte is `dispLo`.
- R9: The sum of base and displacement wraps modulo 2^16.
- R10: `dispBytesNeeded` is combinational. It is 0 for mode 00 except r/m 110, which gives 2. It is 1 for mode 01, 2 for mode 10 and 0 for mode 11.
- R11: Mode 01 with `dispLo`=FC gives the same address as mode 10 with bytes FC FF. An offset of +128 uses mode 10 with bytes 80 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Strobe: fields and operands are valid this cycle |
| modField | input | 2 | Addressing mode field |
| rmField | input | 3 | Register/memory field |
| wBit | input | 1 | Operand width, 1 = 16-bit |
| bxVal | input | 16 | BX contents |
| bpVal | input | 16 | BP contents |
| siVal | input | 16 | SI contents |
| diVal | input | 16 | DI contents |
| dispLo | input | 8 | First (low) displacement byte |
| dispHi | input | 8 | Second (high) displacement byte |
| dispBytesNeeded | output | 2 | Displacement bytes implied by the fields |
| outValid | output | 1 | Registered result valid |
| isRegister | output | 1 | Operand is a register |
| regWide | output | 1 | Register operand is 16-bit |
| regSel | output | 3 | Register code for the register form |
| effAddr | output | 16 | Effective offset, zero in the register form |

## Verification
Two of the block's functions can meet in one cycle. A base sum can carry past bit 15 in the same cycle that a negative sign-extended byte displacement is added. Likewise, a strobe can arrive in the cycle right after an idle cycle in which the held result must not move. The bench drives base registers near FFFF with byte displacements at or above 80. It also places an idle cycle with scrambled inputs between strobes. The address is then checked against a bench model that computes the sum modulo 65536, and the output is checked to stay unchanged across the gap.

// File: rtl/modrm_pkg.sv
package modrm_pkg;

  typedef enum logic [1:0] {
    DISP_NONE = 2'd0,
    DISP_BYTE = 2'd1,
    DISP_WORD = 2'd2
  } dispKind_e;

  // Strobes from the field decoder to the address datapath.
  typedef struct packed {
    logic [3:0] useBase;   // bit0 BX, bit1 BP, bit2 SI, bit3 DI
    dispKind_e  dispKind;
    logic       isReg;
  } eaCtrl_t;

  localparam int unsigned NUM_BASES = 4;

endpackage

// File: rtl/modrm_ctrl.sv
module modrm_ctrl
  import modrm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modField,
  input  logic [2:0] rmField,
  output eaCtrl_t    ctrlOut,
  output logic [1:0] dispBytesNeeded
);

  logic [3:0] baseMask;

  always_comb begin
    unique case (rmField)
      3'd0: baseMask = 4'b0101;   // BX + SI
      3'd1: baseMask = 4'b1001;   // BX + DI
      3'd2: baseMask = 4'b0110;   // BP + SI
      3'd3: baseMask = 4'b1010;   // BP + DI
      3'd4: baseMask = 4'b0100;   // SI
      3'd5: baseMask = 4'b1000;   // DI
      3'd6: baseMask = 4'b0010;   // BP
      default: baseMask = 4'b0001; // BX
    endcase
  end

  always_comb begin
    ctrlOut.isReg    = 1'b0;
    ctrlOut.useBase  = baseMask;
    ctrlOut.dispKind = DISP_NONE;
    unique case (modField)
      2'b00: begin
        if (rmField == 3'b110) begin
          ctrlOut.useBase  = 4'b0000;
          ctrlOut.dispKind = DISP_WORD;
        end
      end
      2'b01: ctrlOut.dispKind = DISP_BYTE;
      2'b10: ctrlOut.dispKind = DISP_WORD;
      default: begin
        ctrlOut.isReg   = 1'b1;
        ctrlOut.useBase = 4'b0000;
      end
    endcase
  end

  always_comb begin
    unique case (ctrlOut.dispKind)
      DISP_BYTE: dispBytesNeeded = 2'd1;
      DISP_WORD: dispBytesNeeded = 2'd2;
      default:   dispBytesNeeded = 2'd0;
    endcase
  end

  // R3: register form selects no base and no displacement
  p_reg_no_base_r3: assert property (@(posedge clk) disable iff (!rstN)
    (modField == 2'b11) |-> (ctrlOut.useBase == 4'b0000 && dispBytesNeeded == 2'd0));

  // R5: at most two registers form a base
  p_base_pair_r5: assert property (@(posedge clk) disable iff (!rstN)
    $countones(ctrlOut.useBase) <= 2);

  // R10: displacement count tracks the mode
  p_disp_count_r10: assert property (@(posedge clk) disable iff (!rstN)
    (modField == 2'b10) |-> (dispBytesNeeded == 2'd2));

endmodule

// File: rtl/modrm_dp.sv
module modrm_dp
  import modrm_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  eaCtrl_t           ctrlIn,
  input  logic [2:0]        rmField,
  input  logic              wBit,
  input  logic [DATA_W-1:0] bxVal,
  input  logic [DATA_W-1:0] bpVal,
  input  logic [DATA_W-1:0] siVal,
  input  logic [DATA_W-1:0] diVal,
  input  logic [DATA_W/2-1:0] dispLo,
  input  logic [DATA_W/2-1:0] dispHi,
  output logic              outValid,
  output logic              isRegister,
  output logic              regWide,
  output logic [2:0]        regSel,
  output logic [DATA_W-1:0] effAddr
);

  localparam int unsigned BYTE_W = DATA_W / 2;

  logic [DATA_W-1:0] baseVals [NUM_BASES];
  logic [DATA_W-1:0] masked   [NUM_BASES];
  logic [DATA_W-1:0] dispExt;
  logic [DATA_W-1:0] addrSum;

  assign baseVals[0] = bxVal;
  assign baseVals[1] = bpVal;
  assign baseVals[2] = siVal;
  assign baseVals[3] = diVal;

  for (genvar g = 0; g < NUM_BASES; g++) begin : g_mask
    assign masked[g] = ctrlIn.useBase[g] ? baseVals[g] : '0;
  end

  always_comb begin
    unique case (ctrlIn.dispKind)
      DISP_BYTE: dispExt = {{BYTE_W{dispLo[BYTE_W-1]}}, dispLo};
      DISP_WORD: dispExt = {dispHi, dispLo};
      default:   dispExt = '0;
    endcase
  end

  assign addrSum = masked[0] + masked[1] + masked[2] + masked[3] + dispExt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      isRegister <= 1'b0;
      regWide    <= 1'b0;
      regSel     <= '0;
      effAddr    <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        isRegister <= ctrlIn.isReg;
        regWide    <= wBit;
        regSel     <= ctrlIn.isReg ? rmField : 3'd0;
        effAddr    <= ctrlIn.isReg ? '0 : addrSum;
      end
    end
  end

  // R2: result appears one cycle after the strobe
  p_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R2: no strobe, no change
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(effAddr) && $stable(isRegister) && $stable(regSel)));

  // R3: register operand drives a zero address
  p_reg_addr_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    isRegister |-> (effAddr == '0));

  // R6: absolute form returns the displacement word unchanged
  p_direct_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !ctrlIn.isReg && ctrlIn.useBase == 4'b0000)
      |=> (effAddr == $past({dispHi, dispLo})));

  // R4: width bit is carried through
  p_width_r4: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> (regWide == $past(wBit)));

endmodule

// File: rtl/modrm_addr_unit.sv
module modrm_addr_unit
  import modrm_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [1:0]          modField,
  input  logic [2:0]          rmField,
  input  logic                wBit,
  input  logic [DATA_W-1:0]   bxVal,
  input  logic [DATA_W-1:0]   bpVal,
  input  logic [DATA_W-1:0]   siVal,
  input  logic [DATA_W-1:0]   diVal,
  input  logic [DATA_W/2-1:0] dispLo,
  input  logic [DATA_W/2-1:0] dispHi,
  output logic [1:0]          dispBytesNeeded,
  output logic                outValid,
  output logic                isRegister,
  output logic                regWide,
  output logic [2:0]          regSel,
  output logic [DATA_W-1:0]   effAddr
);

  eaCtrl_t ctrlBus;

  modrm_ctrl ctrl_i (
    .clk             (clk),
    .rstN            (rstN),
    .modField        (modField),
    .rmField         (rmField),
    .ctrlOut         (ctrlBus),
    .dispBytesNeeded (dispBytesNeeded)
  );

  modrm_dp #(.DATA_W(DATA_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .ctrlIn     (ctrlBus),
    .rmField    (rmField),
    .wBit       (wBit),
    .bxVal      (bxVal),
    .bpVal      (bpVal),
    .siVal      (siVal),
    .diVal      (diVal),
    .dispLo     (dispLo),
    .dispHi     (dispHi),
    .outValid   (outValid),
    .isRegister (isRegister),
    .regWide    (regWide),
    .regSel     (regSel),
    .effAddr    (effAddr)
  );

endmodule

// File: tb/modrm_addr_unit_tb_top.sv
module modrm_addr_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  modField = '0;
  logic [2:0]  rmField = '0;
  logic        wBit = 1'b0;
  logic [15:0] bxVal = '0, bpVal = '0, siVal = '0, diVal = '0;
  logic [7:0]  dispLo = '0, dispHi = '0;
  logic [1:0]  dispBytesNeeded;
  logic        outValid, isRegister, regWide;
  logic [2:0]  regSel;
  logic [15:0] effAddr;

  int errCount = 0;
  int chkCount = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  modrm_addr_unit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .modField(modField),
    .rmField(rmField), .wBit(wBit), .bxVal(bxVal), .bpVal(bpVal),
    .siVal(siVal), .diVal(diVal), .dispLo(dispLo), .dispHi(dispHi),
    .dispBytesNeeded(dispBytesNeeded), .outValid(outValid),
    .isRegister(isRegister), .regWide(regWide), .regSel(regSel),
    .effAddr(effAddr)
  );

  function automatic logic [15:0] refBase(input logic [2:0] rm,
      input logic [15:0] bx, bp, si, di);
    case (rm)
      3'd0: return bx + si;
      3'd1: return bx + di;
      3'd2: return bp + si;
      3'd3: return bp + di;
      3'd4: return si;
      3'd5: return di;
      3'd6: return bp;
      default: return bx;
    endcase
  endfunction

  function automatic logic [15:0] refAddr(input logic [1:0] md, input logic [2:0] rm,
      input logic [15:0] bx, bp, si, di, input logic [7:0] lo, hi);
    logic [15:0] sx;
    sx = {{8{lo[7]}}, lo};
    case (md)
      2'b00: return (rm == 3'b110) ? {hi, lo} : refBase(rm, bx, bp, si, di);
      2'b01: return refBase(rm, bx, bp, si, di) + sx;
      2'b10: return refBase(rm, bx, bp, si, di) + {hi, lo};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [1:0] refCount(input logic [1:0] md, input logic [2:0] rm);
    case (md)
      2'b00: return (rm == 3'b110) ? 2'd2 : 2'd0;
      2'b01: return 2'd1;
      2'b10: return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    chkCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Apply one strobe at a falling edge, check combinational count, then registered outputs.
  task automatic apply(input string req, input logic [1:0] md, input logic [2:0] rm,
      input logic w, input logic [15:0] bx, bp, si, di, input logic [7:0] lo, hi);
    logic [15:0] expAddr;
    modField = md; rmField = rm; wBit = w;
    bxVal = bx; bpVal = bp; siVal = si; diVal = di;
    dispLo = lo; dispHi = hi; inValid = 1'b1;
    #1;
    check({req, " R10 count"}, dispBytesNeeded, refCount(md, rm));
    expAddr = refAddr(md, rm, bx, bp, si, di, lo, hi);
    @(negedge clk);
    inValid = 1'b0;
    check({req, " R2 valid"}, outValid, 1);
    check({req, " addr"}, effAddr, expAddr);
    check({req, " R3 isReg"}, isRegister, (md == 2'b11));
    check({req, " R4 wide"}, regWide, w);
    check({req, " R3 sel"}, regSel, (md == 2'b11) ? rm : 3'd0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errCount++;
      chkCount++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errCount, chkCount);
      $finish;
    end
  end

  initial begin
    logic [15:0] heldAddr;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 outValid", outValid, 0);
    check("R1 effAddr", effAddr, 0);
    check("R1 isRegister", isRegister, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release regSel", regSel, 0);
    check("R1 after release regWide", regWide, 0);

    // R3 register form: DH (w=0, 110) and DI (w=1, 111)
    apply("R3 DH", 2'b11, 3'b110, 1'b0, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 8'h12, 8'h34);
    apply("R3 DI", 2'b11, 3'b111, 1'b1, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 8'h12, 8'h34);

    // R11/R7/R8: [SI-4] two ways give the same address
    apply("R7 SI-4 byte", 2'b01, 3'b100, 1'b0, 16'h0, 16'h0, 16'h1000, 16'h0, 8'hFC, 8'h55);
    check("R11 byte form", effAddr, 16'h0FFC);
    apply("R8 SI-4 word", 2'b10, 3'b100, 1'b0, 16'h0, 16'h0, 16'h1000, 16'h0, 8'hFC, 8'hFF);
    check("R11 word form", effAddr, 16'h0FFC);
    apply("R8 SI+128", 2'b10, 3'b100, 1'b0, 16'h0, 16'h0, 16'h1000, 16'h0, 8'h80, 8'h00);
    check("R11 plus128", effAddr, 16'h1080);

    // R6 direct and plain BP base
    apply("R6 direct", 2'b00, 3'b110, 1'b1, 16'h9999, 16'h7777, 16'h0, 16'h0, 8'h00, 8'h02);
    check("R6 direct value", effAddr, 16'h0200);
    apply("R6 BX+SI no disp", 2'b00, 3'b000, 1'b1, 16'h0100, 16'h0, 16'h0020, 16'h0, 8'hAA, 8'hBB);
    check("R5 BX+SI", effAddr, 16'h0120);
    apply("R5 BP+d8", 2'b01, 3'b110, 1'b0, 16'h0, 16'h0400, 16'h0, 16'h0, 8'h10, 8'hEE);

    // R9 wrap with negative byte displacement carrying past bit 15
    apply("R9 wrap", 2'b01, 3'b000, 1'b1, 16'hFFFF, 16'h0, 16'h0003, 16'h0, 8'h80, 8'h00);
    check("R9 wrap value", effAddr, 16'hFF82);
    apply("R9 wrap word", 2'b10, 3'b011, 1'b1, 16'h0, 16'hFFF0, 16'h0, 16'h0020, 8'hF0, 8'hFF);

    // R2 hold: idle cycle with scrambled inputs leaves outputs unchanged
    heldAddr = effAddr;
    modField = 2'b10; rmField = 3'b001; bxVal = 16'h5A5A; diVal = 16'hA5A5;
    @(negedge clk);
    check("R2 idle valid", outValid, 0);
    check("R2 idle hold", effAddr, heldAddr);
    check("R2 idle isReg", isRegister, 0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0] md;
      logic [2:0] rm;
      md = 2'($urandom % 4);
      rm = 3'($urandom % 8);
      apply("R5 random", md, rm, 1'($urandom % 2),
            16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
            8'($urandom), 8'($urandom));
      if (($urandom % 4) == 0) @(negedge clk);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  end

endmodule